// File: doc/BRIEF.md
# Banked general-register file with dual stack pointers

This block is the general-register file of a 16-bit CPU core. It keeps two banks of seven registers: four data registers (D0..D3), two address registers (AD0, AD1) and a frame register (FRM). Bit 4 of an 8-bit flag register picks the live bank for every access to those seven. The data registers can be reached as 16-bit words. D0 and D1 can also be reached as separate bytes. Two pairs can be reached as 32-bit values: D2:D0 and D3:D1.

Both banks share a user stack pointer and an interrupt stack pointer. Bit 7 of the flag register decides which of the two the alias SP names. The two banks also share a static base register and a 20-bit table base, which is held as a 16-bit low part and a 4-bit high part. The flag register is held here too. It drives the bank and stack choice and is sent out to the core.

Access is through two combinational read ports and one write port. Each port has its own register id, width select and byte-lane select. Reads always use the current contents. A write lands on the next rising clock edge, and a flag change takes effect on the accesses of the next cycle.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears every register in both banks, both stack pointers, the static base, the table base and the flag register to zero. After it, every read returns zero and flags_o is zero.
- R2: The width codes are 0 byte, 1 word, 2 dword and 3 reserved. Register ids are 0 D0, 1 D1, 2 D2, 3 D3, 4 AD0, 5 AD1, 6 FRM, 7 SP, 8 USP, 9 ISP, 10 SB, 11 TBL, 12 TBH and 13 FLG; ids 14 and 15 are unused. A word write to ids 0..6 or 8..11 stores w_data[15:0] at the next rising edge. A word read returns the value zero-extended to 32 bits. A read in the same cycle as the write returns the old value.
- R3: A byte write to D0 or D1 stores w_data[7:0] into bits 7:0 when the lane is 0, or into bits 15:8 when the lane is 1, and leaves the other byte unchanged. A byte read of D0 or D1 returns the selected byte zero-extended.
- R4: A dword write to id 0 stores w_data[15:0] in D0 and w_data[31:16] in D2 on the same edge. A dword write to id 1 does the same for D1 and D3. A dword read of id 0 returns {D2,D0} and of id 1 returns {D3,D1}, both from the same bank.
- R5: A byte access to any id other than 0 or 1, a dword access to any id other than 0 or 1, a word access to id 14 or 15, and any access with width code 3 are all ignored: a write changes no register and a read returns zero.
- R6: Flag bit 4 selects the bank used by ids 0..6 for both reads and writes. After a flag write changes it, the next cycle uses the new bank, and the other bank keeps its contents.
- R7: Id 7 (SP) reads and writes USP when flag bit 7 is 0 and ISP when it is 1. USP and ISP can also be reached directly as ids 8 and 9, and they are the same in both banks.
- R8: SB (id 10) and TBL (id 11) hold 16 bits. TBH (id 12) stores w_data[3:0] and reads back zero-extended. All three are shared by both banks.
- R9: FLG (id 13) stores w_data[7:0] on a word write and reads back zero-extended. flags_o always shows its current value.
- R10: The two read ports decode their id, width and lane independently of each other and of the write port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write enable |
| w_id | input | 4 | Write register id |
| w_wid | input | 2 | Write width code |
| w_lane | input | 1 | Write byte lane (0 low, 1 high) |
| w_data | input | 32 | Write data |
| ra_id | input | 4 | Port A register id |
| ra_wid | input | 2 | Port A width code |
| ra_lane | input | 1 | Port A byte lane |
| ra_data | output | 32 | Port A read data |
| rb_id | input | 4 | Port B register id |
| rb_wid | input | 2 | Port B width code |
| rb_lane | input | 1 | Port B byte lane |
| rb_data | output | 32 | Port B read data |
| flags_o | output | 8 | Current flag register |

## Verification
Read data is combinational. The bench sets each cycle's inputs just after the falling edge and compares both ports 1 ns later, so every read reflects the state written on earlier edges only. A write, including a flag write that moves the bank or the stack selection, is folded into the bench's model at the following rising edge and shows up in the reads of the next cycle. flags_o follows the same timing. The same-cycle read of a register being written is checked against the old value.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int WORD_W = 16;
    localparam int NGPR   = 7;
    localparam int NBANK  = 2;
    localparam int TBH_W  = 4;
    localparam int FLG_W  = 8;
    localparam int FLG_BANK = 4;
    localparam int FLG_STK  = 7;

    typedef enum logic [3:0] {
        RID_D0   = 4'd0,
        RID_D1   = 4'd1,
        RID_D2   = 4'd2,
        RID_D3   = 4'd3,
        RID_AD0  = 4'd4,
        RID_AD1  = 4'd5,
        RID_FRM  = 4'd6,
        RID_SP   = 4'd7,
        RID_USP  = 4'd8,
        RID_ISP  = 4'd9,
        RID_SB   = 4'd10,
        RID_TBL  = 4'd11,
        RID_TBH  = 4'd12,
        RID_FLG  = 4'd13,
        RID_NA14 = 4'd14,
        RID_NA15 = 4'd15
    } reg_id_e;

    typedef enum logic [1:0] {
        WID_BYTE  = 2'd0,
        WID_WORD  = 2'd1,
        WID_DWORD = 2'd2,
        WID_RSV   = 2'd3
    } acc_wid_e;

endpackage

// File: rtl/rf_gpr_banks.sv
module rf_gpr_banks #(
    parameter int NBANK = 2,
    parameter int NGPR  = 7,
    parameter int WW    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NBANK)-1:0]      bank,
    input  logic [NGPR-1:0]               lo_we,
    input  logic [NGPR-1:0]               hi_we,
    input  logic [NGPR-1:0][WW-1:0]       wd,
    output logic [NGPR-1:0][WW-1:0]       act
);
    localparam int HW  = WW / 2;
    localparam int BSW = $clog2(NBANK);

    logic [WW-1:0] bank_q [NBANK][NGPR];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar r = 0; r < NGPR; r++) begin : g_reg
            logic [WW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (bank == BSW'(b)) begin
                    if (lo_we[r]) q[HW-1:0]  <= wd[r][HW-1:0];
                    if (hi_we[r]) q[WW-1:HW] <= wd[r][WW-1:HW];
                end
            end
            assign bank_q[b][r] = q;
        end
    end

    always_comb begin
        for (int r = 0; r < NGPR; r++) begin
            act[r] = bank_q[bank][r];
        end
    end
endmodule

// File: rtl/rf_sys_regs.sv
module rf_sys_regs #(
    parameter int WW    = 16,
    parameter int TBH_W = 4,
    parameter int FLG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WW-1:0]    wd,
    input  logic             we_usp,
    input  logic             we_isp,
    input  logic             we_sb,
    input  logic             we_tbl,
    input  logic             we_tbh,
    input  logic             we_flg,
    output logic [WW-1:0]    usp,
    output logic [WW-1:0]    isp,
    output logic [WW-1:0]    sb,
    output logic [WW-1:0]    tbl,
    output logic [TBH_W-1:0] tbh,
    output logic [FLG_W-1:0] flg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            usp <= '0;
            isp <= '0;
            sb  <= '0;
            tbl <= '0;
            tbh <= '0;
            flg <= '0;
        end else begin
            if (we_usp) usp <= wd;
            if (we_isp) isp <= wd;
            if (we_sb)  sb  <= wd;
            if (we_tbl) tbl <= wd;
            if (we_tbh) tbh <= wd[TBH_W-1:0];
            if (we_flg) flg <= wd[FLG_W-1:0];
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int NGPR  = 7,
    parameter int WW    = 16,
    parameter int TBH_W = 4,
    parameter int FLG_W = 8
) (
    input  logic [3:0]              id,
    input  logic [1:0]              wid,
    input  logic                    lane,
    input  logic                    stk,
    input  logic [NGPR-1:0][WW-1:0] act,
    input  logic [WW-1:0]           usp,
    input  logic [WW-1:0]           isp,
    input  logic [WW-1:0]           sb,
    input  logic [WW-1:0]           tbl,
    input  logic [TBH_W-1:0]        tbh,
    input  logic [FLG_W-1:0]        flg,
    output logic [2*WW-1:0]         data
);
    localparam int HW  = WW / 2;
    localparam int DW  = 2 * WW;
    localparam int GIW = $clog2(NGPR);

    reg_id_e        id_e;
    acc_wid_e       wid_e;
    logic [GIW-1:0] gi;
    logic [GIW-1:0] gi_up;

    assign id_e  = reg_id_e'(id);
    assign wid_e = acc_wid_e'(wid);
    assign gi    = GIW'(id);
    assign gi_up = gi + GIW'(2);

    always_comb begin
        data = '0;
        case (wid_e)
            WID_BYTE: begin
                if (id_e == RID_D0 || id_e == RID_D1) begin
                    data = DW'(lane ? act[gi][WW-1:HW] : act[gi][HW-1:0]);
                end
            end
            WID_WORD: begin
                if (id_e <= RID_FRM) begin
                    data = DW'(act[gi]);
                end else begin
                    case (id_e)
                        RID_SP:  data = DW'(stk ? isp : usp);
                        RID_USP: data = DW'(usp);
                        RID_ISP: data = DW'(isp);
                        RID_SB:  data = DW'(sb);
                        RID_TBL: data = DW'(tbl);
                        RID_TBH: data = DW'(tbh);
                        RID_FLG: data = DW'(flg);
                        default: data = '0;
                    endcase
                end
            end
            WID_DWORD: begin
                if (id_e == RID_D0 || id_e == RID_D1) begin
                    data = {act[gi_up], act[gi]};
                end
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [3:0]  w_id,
    input  logic [1:0]  w_wid,
    input  logic        w_lane,
    input  logic [31:0] w_data,
    input  logic [3:0]  ra_id,
    input  logic [1:0]  ra_wid,
    input  logic        ra_lane,
    output logic [31:0] ra_data,
    input  logic [3:0]  rb_id,
    input  logic [1:0]  rb_wid,
    input  logic        rb_lane,
    output logic [31:0] rb_data,
    output logic [7:0]  flags_o
);
    localparam int HW  = WORD_W / 2;
    localparam int GIW = $clog2(NGPR);

    logic [NGPR-1:0]             lo_we, hi_we;
    logic [NGPR-1:0][WORD_W-1:0] gwd;
    logic [NGPR-1:0][WORD_W-1:0] act;
    logic we_usp, we_isp, we_sb, we_tbl, we_tbh, we_flg;
    logic [WORD_W-1:0] usp, isp, sb, tbl;
    logic [TBH_W-1:0]  tbh;
    logic [FLG_W-1:0]  flg;
    logic              bank, stk;
    reg_id_e           wid_id;
    acc_wid_e          wid_w;
    logic [GIW-1:0]    wi, wi_up;

    assign bank   = flg[FLG_BANK];
    assign stk    = flg[FLG_STK];
    assign wid_id = reg_id_e'(w_id);
    assign wid_w  = acc_wid_e'(w_wid);
    assign wi     = GIW'(w_id);
    assign wi_up  = wi + GIW'(2);

    always_comb begin
        lo_we  = '0;
        hi_we  = '0;
        gwd    = '0;
        we_usp = 1'b0;
        we_isp = 1'b0;
        we_sb  = 1'b0;
        we_tbl = 1'b0;
        we_tbh = 1'b0;
        we_flg = 1'b0;
        if (we) begin
            case (wid_w)
                WID_BYTE: begin
                    if (wid_id == RID_D0 || wid_id == RID_D1) begin
                        lo_we[wi] = ~w_lane;
                        hi_we[wi] = w_lane;
                        gwd[wi]   = {2{w_data[HW-1:0]}};
                    end
                end
                WID_WORD: begin
                    if (wid_id <= RID_FRM) begin
                        lo_we[wi] = 1'b1;
                        hi_we[wi] = 1'b1;
                        gwd[wi]   = w_data[WORD_W-1:0];
                    end else begin
                        case (wid_id)
                            RID_SP:  begin we_isp = stk; we_usp = ~stk; end
                            RID_USP: we_usp = 1'b1;
                            RID_ISP: we_isp = 1'b1;
                            RID_SB:  we_sb  = 1'b1;
                            RID_TBL: we_tbl = 1'b1;
                            RID_TBH: we_tbh = 1'b1;
                            RID_FLG: we_flg = 1'b1;
                            default: ;
                        endcase
                    end
                end
                WID_DWORD: begin
                    if (wid_id == RID_D0 || wid_id == RID_D1) begin
                        lo_we[wi]    = 1'b1;
                        hi_we[wi]    = 1'b1;
                        gwd[wi]      = w_data[WORD_W-1:0];
                        lo_we[wi_up] = 1'b1;
                        hi_we[wi_up] = 1'b1;
                        gwd[wi_up]   = w_data[2*WORD_W-1:WORD_W];
                    end
                end
                default: ;
            endcase
        end
    end

    rf_gpr_banks #(.NBANK(NBANK), .NGPR(NGPR), .WW(WORD_W)) i_banks (
        .clk(clk), .rst(rst), .bank(bank),
        .lo_we(lo_we), .hi_we(hi_we), .wd(gwd), .act(act)
    );

    rf_sys_regs #(.WW(WORD_W), .TBH_W(TBH_W), .FLG_W(FLG_W)) i_sys (
        .clk(clk), .rst(rst), .wd(w_data[WORD_W-1:0]),
        .we_usp(we_usp), .we_isp(we_isp), .we_sb(we_sb),
        .we_tbl(we_tbl), .we_tbh(we_tbh), .we_flg(we_flg),
        .usp(usp), .isp(isp), .sb(sb), .tbl(tbl), .tbh(tbh), .flg(flg)
    );

    rf_read_port #(.NGPR(NGPR), .WW(WORD_W), .TBH_W(TBH_W), .FLG_W(FLG_W)) i_rd_a (
        .id(ra_id), .wid(ra_wid), .lane(ra_lane), .stk(stk), .act(act),
        .usp(usp), .isp(isp), .sb(sb), .tbl(tbl), .tbh(tbh), .flg(flg),
        .data(ra_data)
    );

    rf_read_port #(.NGPR(NGPR), .WW(WORD_W), .TBH_W(TBH_W), .FLG_W(FLG_W)) i_rd_b (
        .id(rb_id), .wid(rb_wid), .lane(rb_lane), .stk(stk), .act(act),
        .usp(usp), .isp(isp), .sb(sb), .tbl(tbl), .tbh(tbh), .flg(flg),
        .data(rb_data)
    );

    assign flags_o = flg;
endmodule

// File: rtl/rf_chk.sv
module rf_chk (
    input logic        clk,
    input logic        rst,
    input logic        we,
    input logic [3:0]  w_id,
    input logic [1:0]  w_wid,
    input logic        w_lane,
    input logic [31:0] w_data,
    input logic [3:0]  ra_id,
    input logic [1:0]  ra_wid,
    input logic        ra_lane,
    input logic [31:0] ra_data,
    input logic [3:0]  rb_id,
    input logic [1:0]  rb_wid,
    input logic        rb_lane,
    input logic [31:0] rb_data,
    input logic [7:0]  flags_o
);
    // R2
    word_wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (we && w_wid == 2'd1 && w_id == 4'd0) |=>
        (ra_id != 4'd0 || ra_wid != 2'd1 || ra_data == {16'h0, $past(w_data[15:0])}));

    // R4
    dword_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (we && w_wid == 2'd2 && w_id == 4'd0) |=>
        (ra_id != 4'd0 || ra_wid != 2'd2 || ra_data == $past(w_data)));

    // R3
    byte_keeps_other_chk: assert property (@(posedge clk) disable iff (rst)
        (we && w_wid == 2'd0 && w_id == 4'd1 && !w_lane && rb_id == 4'd1 && rb_wid == 2'd1) |=>
        (rb_id != 4'd1 || rb_wid != 2'd1 || rb_data[15:8] == $past(rb_data[15:8])));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we && w_wid == 2'd1 && w_id == 4'd13) |=> $stable(flags_o));

    // R7
    sp_alias_user_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags_o[7] && ra_id == 4'd7 && ra_wid == 2'd1 && rb_id == 4'd8 && rb_wid == 2'd1)
        |-> ra_data == rb_data);

    // R5
    reserved_width_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_wid == 2'd3) |-> ra_data == 32'h0);
endmodule

bind banked_regfile rf_chk i_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  w_id = '0;
    logic [1:0]  w_wid = '0;
    logic        w_lane = 1'b0;
    logic [31:0] w_data = '0;
    logic [3:0]  ra_id = '0;
    logic [1:0]  ra_wid = '0;
    logic        ra_lane = 1'b0;
    logic [31:0] ra_data;
    logic [3:0]  rb_id = '0;
    logic [1:0]  rb_wid = '0;
    logic        rb_lane = 1'b0;
    logic [31:0] rb_data;
    logic [7:0]  flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_g [2][7];
    logic [15:0] m_usp, m_isp, m_sb, m_tbl;
    logic [3:0]  m_tbh;
    logic [7:0]  m_flg;

    always #2 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .we(we), .w_id(w_id), .w_wid(w_wid), .w_lane(w_lane),
        .w_data(w_data), .ra_id(ra_id), .ra_wid(ra_wid), .ra_lane(ra_lane),
        .ra_data(ra_data), .rb_id(rb_id), .rb_wid(rb_wid), .rb_lane(rb_lane),
        .rb_data(rb_data), .flags_o(flags_o)
    );

    task automatic mdl_clear();
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 7; r++) m_g[b][r] = '0;
        m_usp = '0; m_isp = '0; m_sb = '0; m_tbl = '0; m_tbh = '0; m_flg = '0;
    endtask

    function automatic logic [31:0] mdl_rd(input logic [3:0] id, input logic [1:0] wd, input logic ln);
        int b = int'(m_flg[4]);
        logic [31:0] v = '0;
        case (wd)
            2'd0: if (id <= 4'd1) v = ln ? {24'h0, m_g[b][id][15:8]} : {24'h0, m_g[b][id][7:0]};
            2'd1: begin
                if (id <= 4'd6) v = {16'h0, m_g[b][id]};
                else case (id)
                    4'd7:  v = {16'h0, (m_flg[7] ? m_isp : m_usp)};
                    4'd8:  v = {16'h0, m_usp};
                    4'd9:  v = {16'h0, m_isp};
                    4'd10: v = {16'h0, m_sb};
                    4'd11: v = {16'h0, m_tbl};
                    4'd12: v = {28'h0, m_tbh};
                    4'd13: v = {24'h0, m_flg};
                    default: v = '0;
                endcase
            end
            2'd2: if (id <= 4'd1) v = {m_g[b][id + 2], m_g[b][id]};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic mdl_wr(input logic [3:0] id, input logic [1:0] wd, input logic ln, input logic [31:0] d);
        int b = int'(m_flg[4]);
        case (wd)
            2'd0: if (id <= 4'd1) begin
                if (ln) m_g[b][id][15:8] = d[7:0];
                else    m_g[b][id][7:0]  = d[7:0];
            end
            2'd1: begin
                if (id <= 4'd6) m_g[b][id] = d[15:0];
                else case (id)
                    4'd7:  if (m_flg[7]) m_isp = d[15:0]; else m_usp = d[15:0];
                    4'd8:  m_usp = d[15:0];
                    4'd9:  m_isp = d[15:0];
                    4'd10: m_sb  = d[15:0];
                    4'd11: m_tbl = d[15:0];
                    4'd12: m_tbh = d[3:0];
                    4'd13: m_flg = d[7:0];
                    default: ;
                endcase
            end
            2'd2: if (id <= 4'd1) begin
                m_g[b][id]     = d[15:0];
                m_g[b][id + 2] = d[31:16];
            end
            default: ;
        endcase
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // One clock cycle: drive after the falling edge, compare reads 1 ns later,
    // fold the write into the model at the rising edge.
    task automatic cyc(input logic wen, input logic [3:0] wi, input logic [1:0] ww, input logic wl,
                       input logic [31:0] wdat,
                       input logic [3:0] ai, input logic [1:0] aw, input logic al,
                       input logic [3:0] bi, input logic [1:0] bw, input logic bl,
                       input string tag);
        @(negedge clk);
        we = wen; w_id = wi; w_wid = ww; w_lane = wl; w_data = wdat;
        ra_id = ai; ra_wid = aw; ra_lane = al;
        rb_id = bi; rb_wid = bw; rb_lane = bl;
        #1;
        check(ra_data, mdl_rd(ai, aw, al), {tag, " port A"});
        check(rb_data, mdl_rd(bi, bw, bl), {tag, " port B"});
        check({24'h0, flags_o}, {24'h0, m_flg}, {tag, " flags"});
        @(posedge clk);
        if (wen) mdl_wr(wi, ww, wl, wdat);
    endtask

    task automatic rd(input logic [3:0] ai, input logic [1:0] aw, input logic al,
                      input logic [3:0] bi, input logic [1:0] bw, input logic bl, input string tag);
        cyc(1'b0, 4'd0, 2'd0, 1'b0, 32'h0, ai, aw, al, bi, bw, bl, tag);
    endtask

    task automatic wr(input logic [3:0] wi, input logic [1:0] ww, input logic wl, input logic [31:0] d,
                      input string tag);
        cyc(1'b1, wi, ww, wl, d, wi, ww, wl, wi, 2'd1, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        mdl_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl_clear();
        do_reset();

        // R1: all ids read zero after reset
        for (int i = 0; i < 16; i++) rd(4'(i), 2'd1, 1'b0, 4'(i), 2'd2, 1'b0, "R1 reset");

        // R2: same-cycle read returns old value, next cycle the new one
        cyc(1'b1, 4'd0, 2'd1, 1'b0, 32'hdead1234, 4'd0, 2'd1, 1'b0, 4'd0, 2'd1, 1'b0, "R2 same cycle");
        rd(4'd0, 2'd1, 1'b0, 4'd0, 2'd2, 1'b0, "R2 after write");
        wr(4'd5, 2'd1, 1'b0, 32'h0000a5a5, "R2 AD1");
        rd(4'd5, 2'd1, 1'b0, 4'd6, 2'd1, 1'b0, "R2 AD1 readback");

        // R3: byte lanes of D1
        wr(4'd1, 2'd0, 1'b1, 32'h000000ab, "R3 high lane");
        wr(4'd1, 2'd0, 1'b0, 32'h000000cd, "R3 low lane");
        rd(4'd1, 2'd1, 1'b0, 4'd1, 2'd0, 1'b1, "R3 word and high byte");
        rd(4'd1, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1, "R3 low byte");

        // R4: dword pairs
        wr(4'd0, 2'd2, 1'b0, 32'h11112222, "R4 pair D2D0");
        rd(4'd2, 2'd1, 1'b0, 4'd0, 2'd1, 1'b0, "R4 halves");
        wr(4'd1, 2'd2, 1'b0, 32'h33334444, "R4 pair D3D1");
        rd(4'd1, 2'd2, 1'b0, 4'd3, 2'd1, 1'b0, "R4 dword read");

        // R5: ignored accesses
        wr(4'd4, 2'd0, 1'b0, 32'h000000ff, "R5 byte to AD0");
        wr(4'd5, 2'd2, 1'b0, 32'hffffffff, "R5 dword to AD1");
        wr(4'd0, 2'd3, 1'b0, 32'hffffffff, "R5 reserved width");
        wr(4'd14, 2'd1, 1'b0, 32'hffffffff, "R5 unused id");
        rd(4'd4, 2'd1, 1'b0, 4'd5, 2'd1, 1'b0, "R5 AD0 AD1 unchanged");
        rd(4'd0, 2'd3, 1'b0, 4'd8, 2'd0, 1'b0, "R5 reserved reads zero");

        // R6: switch bank, other bank preserved
        wr(4'd13, 2'd1, 1'b0, 32'h00000010, "R6 select bank 1");
        rd(4'd0, 2'd1, 1'b0, 4'd1, 2'd2, 1'b0, "R6 bank 1 empty");
        wr(4'd0, 2'd1, 1'b0, 32'h00005555, "R6 write bank 1");
        cyc(1'b1, 4'd13, 2'd1, 1'b0, 32'h00000000, 4'd0, 2'd1, 1'b0, 4'd0, 2'd2, 1'b0, "R6 switch back");
        rd(4'd0, 2'd1, 1'b0, 4'd1, 2'd2, 1'b0, "R6 bank 0 preserved");

        // R7: stack alias
        wr(4'd7, 2'd1, 1'b0, 32'h00001000, "R7 SP to USP");
        wr(4'd13, 2'd1, 1'b0, 32'h00000090, "R7 select ISP");
        wr(4'd7, 2'd1, 1'b0, 32'h00002000, "R7 SP to ISP");
        rd(4'd8, 2'd1, 1'b0, 4'd9, 2'd1, 1'b0, "R7 direct USP ISP");
        rd(4'd7, 2'd1, 1'b0, 4'd6, 2'd1, 1'b0, "R7 SP in bank 1");

        // R8: shared SB and table base
        wr(4'd12, 2'd1, 1'b0, 32'h0000ffff, "R8 TBH");
        wr(4'd11, 2'd1, 1'b0, 32'h00009876, "R8 TBL");
        wr(4'd10, 2'd1, 1'b0, 32'h00004321, "R8 SB");
        wr(4'd13, 2'd1, 1'b0, 32'h00000000, "R8 to bank 0");
        rd(4'd12, 2'd1, 1'b0, 4'd11, 2'd1, 1'b0, "R8 table base shared");
        rd(4'd10, 2'd1, 1'b0, 4'd7, 2'd1, 1'b0, "R8 SB shared");

        // R9: flag register width
        wr(4'd13, 2'd1, 1'b0, 32'hffff00ef, "R9 flags write");
        rd(4'd13, 2'd1, 1'b0, 4'd13, 2'd0, 1'b0, "R9 flags read");

        // R10: constrained random mix on both ports
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] wi = 4'($urandom_range(0, 15));
            logic [1:0] ww = ($urandom_range(0, 9) < 6) ? 2'd1 : 2'($urandom_range(0, 3));
            logic [31:0] dv = $urandom();
            if (wi == 4'd13) dv = dv & 32'h000000ff;
            cyc(1'($urandom_range(0, 1)), wi, ww, 1'($urandom_range(0, 1)), dv,
                4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                "R10 random");
        end

        // R1: reset after traffic clears everything
        do_reset();
        for (int i = 0; i < 16; i++) rd(4'(i), 2'd1, 1'b0, 4'(i), 2'd2, 1'b0, "R1 reset again");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule